// File: doc/BRIEF.md
# Flash Completion Polling Engine

This engine sits on the host side of a parallel flash device and decides when an already issued program or erase has finished. Once started it repeatedly reads the flash status byte through a synchronous request/acknowledge read port. It interprets each returned byte with one of two selectable methods and ends with exactly one of three results: pass, fail or timeout. The issuing of the program or erase command itself happens before the engine is started and is handled elsewhere.

In data-polling mode the engine compares bit 7 of every status read against the expected value of bit 7. That value is bit 7 of the byte being programmed, or 1 for an erase, because erased cells read as all ones. In toggle mode it watches bit 6 across consecutive reads; bit 6 stops changing once the operation is over. In both modes bit 5 is the device error flag. The error flag can appear in the same read in which the operation completes, so the engine never declares a failure from bit 5 alone. It always re-reads first to confirm.

On a failure the engine can write the reset command byte to the flash, so that the device accepts new commands again. A programmable cycle limit stops a poll that never converges and reports it as a timeout, which is kept apart from a fail.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `rdReq`, `wrReq`, `done`, `passFlag`, `failFlag` and `timeoutFlag` are all 0.
- R2: Only one read is outstanding at a time. `rdReq` stays high until a cycle with `rdAck` high. Every read of a run presents the address captured at start on `rdAddr`.
- R3: In data-polling mode, a status read whose bit 7 equals the expected bit 7 ends the run with pass.
- R4: In data-polling mode, a read whose bit 7 differs from the expected bit 7 while bit 5 is 0 leads to another read.
- R5: In data-polling mode, a read whose bit 7 differs while bit 5 is 1 leads to exactly one confirming read. The run passes if bit 7 of that read matches and fails otherwise.
- R6: When `startErase` is 1, the expected bit 7 is 1 whatever `startExpect` holds. When it is 0, the expected bit 7 is bit 7 of `startExpect`.
- R7: In toggle mode (`startToggle` = 1), the first read only sets the reference value of bit 6. A later read whose bit 6 equals the previous read's bit 6 ends with pass. A changed bit 6 with bit 5 at 0 takes the new value as the reference and reads again.
- R8: In toggle mode, a changed bit 6 together with bit 5 at 1 leads to exactly two further reads. The run passes if bit 6 is equal in those two reads and fails otherwise.
- R9: On a fail with `startResetOnFail` = 1, the engine makes one write of F0h to the poll address on `wrReq`/`wrAddr`/`wrData`, and it reports completion only after `wrAck`. With `startResetOnFail` = 0, or on pass or timeout, no write occurs.
- R10: If at least `timeoutLimit` cycles have passed since start when an ordinary re-poll (R4, R7) would be issued, the run ends with `timeoutFlag` and not with `failFlag`.
- R11: `startValid` is ignored while `busy` is 1. Address, mode, expected value and options of the running poll stay as they were.
- R12: `done` is a one-cycle pulse at the end of every run. At most one of `passFlag`, `failFlag` and `timeoutFlag` is set; it is set in the cycle of `done` and held until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a poll run (accepted only when idle) |
| startAddr | input | ADDR_W | Valid address: programmed byte or any address in the erasing block |
| startExpect | input | 8 | Byte that was programmed (data-polling reference) |
| startErase | input | 1 | 1: erase in progress, expected bit 7 is 1 |
| startToggle | input | 1 | 0: data polling on bit 7, 1: toggle detection on bit 6 |
| startResetOnFail | input | 1 | 1: write the reset command after a fail |
| timeoutLimit | input | CNT_W | Cycle limit for the run |
| busy | output | 1 | Run in progress |
| rdReq | output | 1 | Status read request |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read completed, `rdData` valid |
| rdData | input | 8 | Returned status byte |
| wrReq | output | 1 | Reset-command write request |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | 8 | Write data (F0h) |
| wrAck | input | 1 | Write completed |
| done | output | 1 | One-cycle end-of-run pulse |
| passFlag | output | 1 | Run ended with pass |
| failFlag | output | 1 | Run ended with fail |
| timeoutFlag | output | 1 | Run ended with timeout |

## Verification
The hardest situations to reach are the confirmation paths. There the error bit shows up in a read, and the outcome depends on the next one or two reads: in some cases the operation in fact completed in the same read, in others it really failed. A scripted flash model in the bench returns a chosen sequence of status bytes on successive acknowledged reads. The vector table sets up sequences where bit 5 rises with or without bit 7 matching afterwards, and where bit 6 settles or keeps toggling after the error. The timeout and the ignored start are reached with a script that never converges, during which a second start with different options is pulsed.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EVAL,
    ST_WRITE
  } stateT;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_NORM,
    PH_CONFA,
    PH_CONFB
  } phaseT;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_PASS,
    RES_FAIL,
    RES_TMO
  } resultT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture start parameters, clear cycle counter
    logic capture;  // latch returned status byte
    logic setRef;   // take bit 6 of latched byte as toggle reference
    logic count;    // advance cycle counter
  } strobeT;

  localparam logic [7:0] RESET_CMD = 8'hF0;

endpackage

// File: rtl/fpe_dpath.sv
module fpe_dpath
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        startExpect,
  input  logic              startErase,
  input  logic              startToggle,
  input  logic              startResetOnFail,
  input  logic [CNT_W-1:0]  timeoutLimit,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] pollAddr,
  output logic              toggleMode,
  output logic              resetOnFail,
  output logic              bit7Match,
  output logic              bit5Set,
  output logic              bit6Same,
  output logic              timeHit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ADDR_W-1:0] addrQ;
  logic              expBit7Q;
  logic              toggleQ;
  logic              rofQ;
  logic [CNT_W-1:0]  limitQ;
  logic [7:0]        dataQ;
  logic              refBit6Q;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      expBit7Q <= 1'b0;
      toggleQ  <= 1'b0;
      rofQ     <= 1'b0;
      limitQ   <= '0;
    end else if (stb.load) begin
      addrQ    <= startAddr;
      expBit7Q <= startErase ? 1'b1 : startExpect[7];
      toggleQ  <= startToggle;
      rofQ     <= startResetOnFail;
      limitQ   <= timeoutLimit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ    <= '0;
      refBit6Q <= 1'b0;
    end else begin
      if (stb.capture) dataQ <= rdData;
      if (stb.setRef)  refBit6Q <= dataQ[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          cntQ <= '0;
    else if (stb.load)                  cntQ <= '0;
    else if (stb.count && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  assign pollAddr    = addrQ;
  assign toggleMode  = toggleQ;
  assign resetOnFail = rofQ;
  assign bit7Match   = (dataQ[7] == expBit7Q);
  assign bit5Set     = dataQ[5];
  assign bit6Same    = (dataQ[6] == refBit6Q);
  assign timeHit     = (cntQ >= limitQ);

  // R10: the cycle counter never wraps back while a run is counting
  a_r10_cnt_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (stb.count && !stb.load) |=> (cntQ >= $past(cntQ)));

endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
  import fpe_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  input  logic   startToggle,
  input  logic   rdAck,
  input  logic   wrAck,
  input  logic   toggleMode,
  input  logic   resetOnFail,
  input  logic   bit7Match,
  input  logic   bit5Set,
  input  logic   bit6Same,
  input  logic   timeHit,
  output strobeT stb,
  output logic   busy,
  output logic   rdReq,
  output logic   wrReq,
  output logic   done,
  output logic   passFlag,
  output logic   failFlag,
  output logic   timeoutFlag
);

  stateT  stQ, stNext;
  phaseT  phQ, phNext;
  resultT resQ, resNext;
  logic   endNow;
  resultT endRes;

  // evaluation of a latched status byte
  logic   haveRes;
  resultT evalRes;
  logic   rePoll;
  logic   reRead;

  always_comb begin
    haveRes = 1'b0;
    evalRes = RES_NONE;
    rePoll  = 1'b0;
    reRead  = 1'b0;
    phNext  = phQ;
    stb     = '0;
    if (stQ == ST_EVAL) begin
      if (!toggleMode) begin
        if (phQ == PH_CONFA) begin
          haveRes = 1'b1;
          evalRes = bit7Match ? RES_PASS : RES_FAIL;
        end else if (bit7Match) begin
          haveRes = 1'b1;
          evalRes = RES_PASS;
        end else if (!bit5Set) begin
          rePoll = 1'b1;
        end else begin
          reRead = 1'b1;
          phNext = PH_CONFA;
        end
      end else begin
        unique case (phQ)
          PH_FIRST: begin
            stb.setRef = 1'b1;
            reRead     = 1'b1;
            phNext     = PH_NORM;
          end
          PH_NORM: begin
            if (bit6Same) begin
              haveRes = 1'b1;
              evalRes = RES_PASS;
            end else if (!bit5Set) begin
              stb.setRef = 1'b1;
              rePoll     = 1'b1;
            end else begin
              reRead = 1'b1;
              phNext = PH_CONFA;
            end
          end
          PH_CONFA: begin
            stb.setRef = 1'b1;
            reRead     = 1'b1;
            phNext     = PH_CONFB;
          end
          PH_CONFB: begin
            haveRes = 1'b1;
            evalRes = bit6Same ? RES_PASS : RES_FAIL;
          end
          default: ;
        endcase
      end
      if (rePoll && timeHit) begin
        haveRes = 1'b1;
        evalRes = RES_TMO;
      end
    end
    if (stQ == ST_IDLE && startValid) begin
      stb.load = 1'b1;
      phNext   = startToggle ? PH_FIRST : PH_NORM;
    end
    stb.count   = (stQ != ST_IDLE);
    stb.capture = (stQ == ST_READ) && rdAck;
  end

  always_comb begin
    stNext  = stQ;
    resNext = resQ;
    endNow  = 1'b0;
    endRes  = RES_NONE;
    unique case (stQ)
      ST_IDLE:  if (startValid) stNext = ST_READ;
      ST_READ:  if (rdAck) stNext = ST_EVAL;
      ST_EVAL: begin
        if (haveRes) begin
          if (evalRes == RES_FAIL && resetOnFail) begin
            stNext  = ST_WRITE;
            resNext = RES_FAIL;
          end else begin
            stNext = ST_IDLE;
            endNow = 1'b1;
            endRes = evalRes;
          end
        end else if (rePoll || reRead) begin
          stNext = ST_READ;
        end
      end
      ST_WRITE: begin
        if (wrAck) begin
          stNext = ST_IDLE;
          endNow = 1'b1;
          endRes = resQ;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= ST_IDLE;
      phQ  <= PH_NORM;
      resQ <= RES_NONE;
    end else begin
      stQ  <= stNext;
      phQ  <= phNext;
      resQ <= resNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done        <= 1'b0;
      passFlag    <= 1'b0;
      failFlag    <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      done <= endNow;
      if (stb.load) begin
        passFlag    <= 1'b0;
        failFlag    <= 1'b0;
        timeoutFlag <= 1'b0;
      end else if (endNow) begin
        passFlag    <= (endRes == RES_PASS);
        failFlag    <= (endRes == RES_FAIL);
        timeoutFlag <= (endRes == RES_TMO);
      end
    end
  end

  assign busy  = (stQ != ST_IDLE);
  assign rdReq = (stQ == ST_READ);
  assign wrReq = (stQ == ST_WRITE);

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> rdReq);

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> wrReq);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq));

  a_r12_onehot_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({passFlag, failFlag, timeoutFlag}));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  a_r10_timeout_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> timeHit);

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        startExpect,
  input  logic              startErase,
  input  logic              startToggle,
  input  logic              startResetOnFail,
  input  logic [CNT_W-1:0]  timeoutLimit,
  output logic              busy,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [7:0]        rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  input  logic              wrAck,
  output logic              done,
  output logic              passFlag,
  output logic              failFlag,
  output logic              timeoutFlag
);

  strobeT            stb;
  logic [ADDR_W-1:0] pollAddr;
  logic              toggleMode;
  logic              resetOnFail;
  logic              bit7Match;
  logic              bit5Set;
  logic              bit6Same;
  logic              timeHit;

  fpe_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpath (
    .clk              (clk),
    .rstN             (rstN),
    .stb              (stb),
    .startAddr        (startAddr),
    .startExpect      (startExpect),
    .startErase       (startErase),
    .startToggle      (startToggle),
    .startResetOnFail (startResetOnFail),
    .timeoutLimit     (timeoutLimit),
    .rdData           (rdData),
    .pollAddr         (pollAddr),
    .toggleMode       (toggleMode),
    .resetOnFail      (resetOnFail),
    .bit7Match        (bit7Match),
    .bit5Set          (bit5Set),
    .bit6Same         (bit6Same),
    .timeHit          (timeHit)
  );

  fpe_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .startToggle (startToggle),
    .rdAck       (rdAck),
    .wrAck       (wrAck),
    .toggleMode  (toggleMode),
    .resetOnFail (resetOnFail),
    .bit7Match   (bit7Match),
    .bit5Set     (bit5Set),
    .bit6Same    (bit6Same),
    .timeHit     (timeHit),
    .stb         (stb),
    .busy        (busy),
    .rdReq       (rdReq),
    .wrReq       (wrReq),
    .done        (done),
    .passFlag    (passFlag),
    .failFlag    (failFlag),
    .timeoutFlag (timeoutFlag)
  );

  assign rdAddr = pollAddr;
  assign wrAddr = pollAddr;
  assign wrData = RESET_CMD;

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(rdAddr));

endmodule

// File: tb/flash_poll_engine_test.sv
module flash_poll_engine_test;

  localparam int AW = 17;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [7:0]    startExpect = '0;
  logic          startErase = 1'b0;
  logic          startToggle = 1'b0;
  logic          startResetOnFail = 1'b0;
  logic [CW-1:0] timeoutLimit = '0;
  logic          busy, rdReq, wrReq, done, passFlag, failFlag, timeoutFlag;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [7:0]    wrData;
  logic          rdAck = 1'b0;
  logic [7:0]    rdData = '0;
  logic          wrAck = 1'b0;

  always #2 clk = ~clk;

  flash_poll_engine #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .startExpect(startExpect), .startErase(startErase), .startToggle(startToggle),
    .startResetOnFail(startResetOnFail), .timeoutLimit(timeoutLimit),
    .busy(busy), .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdData(rdData),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .wrAck(wrAck),
    .done(done), .passFlag(passFlag), .failFlag(failFlag), .timeoutFlag(timeoutFlag)
  );

  int errors = 0;
  int checks = 0;

  // scripted flash model
  logic [7:0]    scr [6];
  logic [AW-1:0] expAddr = '0;
  int            rdIdx = 0;
  int            addrErr = 0;
  int            wrCount = 0;
  logic [7:0]    wrSeenData = '0;
  logic [AW-1:0] wrSeenAddr = '0;
  logic          clrModel = 1'b0;

  always @(posedge clk) begin
    if (clrModel) begin
      rdIdx   <= 0;
      addrErr <= 0;
      wrCount <= 0;
    end else begin
      if (rdReq && !rdAck) begin
        rdAck  <= 1'b1;
        rdData <= scr[(rdIdx > 5) ? 5 : rdIdx];
        rdIdx  <= rdIdx + 1;
        if (rdAddr != expAddr) addrErr <= addrErr + 1;
      end else begin
        rdAck <= 1'b0;
      end
      if (wrReq && !wrAck) begin
        wrAck      <= 1'b1;
        wrCount    <= wrCount + 1;
        wrSeenData <= wrData;
        wrSeenAddr <= wrAddr;
      end else begin
        wrAck <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // result codes: 0 pass, 1 fail, 2 timeout
  function automatic int resCode();
    return passFlag ? 0 : failFlag ? 1 : timeoutFlag ? 2 : 3;
  endfunction

  task automatic runOne(input bit tog, input bit ers, input logic [7:0] expv,
                        input logic [47:0] script, input bit rof,
                        input logic [CW-1:0] lim, input logic [AW-1:0] addr);
    @(negedge clk);
    for (int i = 0; i < 6; i++) scr[i] = script[47 - 8*i -: 8];
    expAddr = addr;
    clrModel = 1'b1;
    @(negedge clk);
    clrModel = 1'b0;
    startAddr = addr; startExpect = expv; startErase = ers;
    startToggle = tog; startResetOnFail = rof; timeoutLimit = lim;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    startAddr = ~addr; startToggle = ~tog; startErase = 1'b0;
    while (!done) @(negedge clk);
  endtask

  // {toggle, erase, expect[7:0], script[47:0], result[1:0], reads[2:0]}
  localparam int NV = 11;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h5A, 48'h5A_00_00_00_00_00, 2'd0, 3'd1}, // R3
    {1'b0, 1'b0, 8'h5A, 48'h80_80_5A_00_00_00, 2'd0, 3'd3}, // R4
    {1'b0, 1'b0, 8'h5A, 48'hA0_5A_00_00_00_00, 2'd0, 3'd2}, // R5 pass on confirm
    {1'b0, 1'b0, 8'h5A, 48'hA0_A0_00_00_00_00, 2'd1, 3'd2}, // R5 fail on confirm
    {1'b0, 1'b1, 8'h00, 48'h00_00_FF_00_00_00, 2'd0, 3'd3}, // R6 erase
    {1'b0, 1'b1, 8'h00, 48'h20_20_00_00_00_00, 2'd1, 3'd2}, // R6 erase fail
    {1'b1, 1'b0, 8'h00, 48'h40_40_00_00_00_00, 2'd0, 3'd2}, // R7
    {1'b1, 1'b0, 8'h00, 48'h40_00_40_40_00_00, 2'd0, 3'd4}, // R7 keeps polling
    {1'b1, 1'b0, 8'h00, 48'h40_20_00_00_00_00, 2'd0, 3'd4}, // R8 stable
    {1'b1, 1'b0, 8'h00, 48'h40_20_40_00_00_00, 2'd1, 3'd4}, // R8 toggles
    {1'b1, 1'b0, 8'h00, 48'h00_60_60_20_00_00, 2'd1, 3'd4}  // R8 toggles
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !rdReq && !wrReq && !done, "R1", "idle outputs",
          {busy, rdReq, wrReq, done}, 0);
    check(!passFlag && !failFlag && !timeoutFlag, "R1", "flags clear",
          {passFlag, failFlag, timeoutFlag}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      runOne(VEC[v][62], VEC[v][61], VEC[v][60:53], VEC[v][52:5], 1'b0,
             16'd1000, 17'h04000 + AW'(v));
      check(resCode() == int'(VEC[v][4:3]), "R3-R8 vector", "result",
            resCode(), int'(VEC[v][4:3]));
      check(rdIdx == int'(VEC[v][2:0]), "R4 R5 R8 vector", "read count",
            rdIdx, int'(VEC[v][2:0]));
      check(addrErr == 0, "R2", "read address mismatches", addrErr, 0);
      check(wrCount == 0, "R9", "writes with reset disabled", wrCount, 0);
      @(negedge clk);
      check(!done, "R12", "done is one cycle", done, 0);
      check(resCode() == int'(VEC[v][4:3]), "R12", "flag held", resCode(),
            int'(VEC[v][4:3]));
    end

    // R9 reset write after a fail
    runOne(1'b0, 1'b0, 8'h5A, 48'hA0_A0_00_00_00_00, 1'b1, 16'd1000, 17'h1C005);
    check(failFlag, "R9", "fail with reset write", resCode(), 1);
    check(wrCount == 1, "R9", "one reset write", wrCount, 1);
    check(wrSeenData == 8'hF0, "R9", "reset data", wrSeenData, 8'hF0);
    check(wrSeenAddr == 17'h1C005, "R9", "reset address", wrSeenAddr, 17'h1C005);

    // R9 no write on pass even when enabled
    runOne(1'b0, 1'b0, 8'h5A, 48'h5A_00_00_00_00_00, 1'b1, 16'd1000, 17'h00010);
    check(passFlag && wrCount == 0, "R9", "no write on pass", wrCount, 0);

    // R10 + R11: never converging script, second start pulsed mid-run
    begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) scr[i] = 8'h80;
      expAddr = 17'h08123;
      clrModel = 1'b1;
      @(negedge clk);
      clrModel = 1'b0;
      startAddr = 17'h08123; startExpect = 8'h00; startErase = 1'b0;
      startToggle = 1'b0; startResetOnFail = 1'b1; timeoutLimit = 16'd40;
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
      repeat (5) @(negedge clk);
      // R11: this start has toggle mode, which would pass on the 0x80 script
      startAddr = 17'h00777; startToggle = 1'b1; startErase = 1'b1;
      startValid = 1'b1;
      @(negedge clk);
      startValid = 1'b0;
      while (!done) @(negedge clk);
      check(timeoutFlag && !failFlag && !passFlag, "R10", "timeout result",
            resCode(), 2);
      check(wrCount == 0, "R10", "no reset write on timeout", wrCount, 0);
      check(rdIdx > 3, "R10", "polled until limit", rdIdx, 4);
      check(addrErr == 0, "R11", "address kept despite start", addrErr, 0);
    end

    // R12 flags cleared by the next accepted start
    runOne(1'b1, 1'b0, 8'h00, 48'h40_40_00_00_00_00, 1'b0, 16'd1000, 17'h00001);
    check(passFlag && !timeoutFlag, "R12", "flags replaced", resCode(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule